// File: doc/BRIEF.md
# Vector Integer Compare Mask Writer

This block runs one element-wise integer comparison of a vector instruction. It compares each element of a source register group with either the matching element of a second group or a single scalar. One result bit per element goes into a single destination mask register. It covers element indices from the start index up to, but not including, the vector length. Eight relations are supported at element widths of 8, 16, 32 and 64 bits. The group size can be 1, 2, 4 or 8 registers.

The block does not hold the register file. It reaches a 32-entry file of VLEN-bit registers through one combinational read port and one write port. It reads the mask register v0 (only when masking is on) and the old destination register. It then fetches source elements one at a time and updates bits in a local copy of the destination. At the end it writes that copy back in a single write. Because of this read-modify-write, every bit that is not computed keeps its old value, whatever tail policy the surrounding machine uses.

A command is accepted on a `start` pulse while the block is idle. Completion is a one-cycle `done`. On a legal command, `done` comes with `vstart_clr` and `vs_dirty`. On an illegal command, `done` comes with `illegal` instead.

The control is a state machine with these states:
- ST_IDLE: waits for `start`, then goes to ST_CHECK.
- ST_CHECK: checks alignment. An illegal command goes to ST_DONE. A masked command goes to ST_LOAD_MASK. Otherwise it goes to ST_LOAD_DEST.
- ST_LOAD_MASK: goes to ST_LOAD_DEST.
- ST_LOAD_DEST: goes to ST_SCAN.
- ST_SCAN: when the index reaches vl, goes to ST_WRITE. For an active element, goes to ST_FETCH_A. For an inactive element, stays and steps the index.
- ST_FETCH_A: goes back to ST_SCAN for a scalar command, or to ST_FETCH_B for a vector command.
- ST_FETCH_B: goes to ST_SCAN.
- ST_WRITE: goes to ST_DONE.
- ST_DONE: goes to ST_IDLE.

Top module: `vcmp_mask_writer`

## Requirements
- R1: The result for element i is stored in destination register bit i, which is bit i mod 8 of byte i/8, least significant bit first.
- R2: The `op` codes are 0 eq, 1 ne, 2 ltu, 3 lt, 4 leu, 5 le, 6 gtu, 7 gt. Unsigned relations and eq/ne compare both operands cut to the element width.
- R3: Signed relations (3, 5, 7) compare both operands sign-extended from the element width.
- R4: The `ew` codes are 0=8, 1=16, 2=32, 3=64 bits. With E elements per register (VLEN/width), source element i is read from register base + i/E, at byte offset (i mod E)*width/8, little-endian, and zero-extended.
- R5: Destination bits at indices vl and above keep their old value.
- R6: Destination bits below `vstart` keep their old value. A command with vstart >= vl leaves the destination unchanged and still completes normally.
- R7: With `vm`=0, element i is active only if bit i of v0, as it was when the command started, is set. Inactive bits keep their old value. With `vm`=1, all elements are active. The destination may be v0.
- R8: With `use_scalar`=1, the 64-bit `scalar` is the second operand for every element, cut or sign-extended like a vector element. `vs1` is then neither read nor checked.
- R9: `grp_lg` selects a group of 2^grp_lg registers. If `vs2`, or `vs1` when it is used, is not a multiple of the group size or does not fit inside the 32 registers, the command ends with `done` and `illegal`. There is no register write, and no `vstart_clr` or `vs_dirty`.
- R10: A legal command performs exactly one write, to `vd`. It then raises `done`, `vstart_clr` and `vs_dirty` together for one cycle. These flags never appear without `done`.
- R11: `start` is accepted only while `busy` is low. A `start` while busy is ignored. After reset the block is idle with no write and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken while idle |
| op | input | 3 | Relation code |
| ew | input | 2 | Element width code |
| grp_lg | input | 2 | Log2 of the register group size |
| vd | input | 5 | Destination mask register |
| vs2 | input | 5 | First source group base |
| vs1 | input | 5 | Second source group base |
| use_scalar | input | 1 | Use `scalar` as the second operand |
| scalar | input | 64 | Pre-extended scalar operand |
| vm | input | 1 | 1 = unmasked, 0 = masked by v0 |
| vl | input | $clog2(VLEN)+1 | Vector length |
| vstart | input | $clog2(VLEN)+1 | First element index |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Completion was an illegal command |
| vstart_clr | output | 1 | Request to clear the start index |
| vs_dirty | output | 1 | Request to mark vector state dirty |
| rf_rd_idx | output | 5 | Register file read index |
| rf_rd_data | input | VLEN | Register file read data, same cycle |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | VLEN | Register file write data |

## Verification
The bench targets these corner cases:
- Operands with the top bit of the element set. A design that mixed up signed and unsigned extension would flip lt/ltu and gt/gtu results on them.
- A scalar with garbage above the element width. A design that did not cut the scalar would miss equalities.
- Destinations pre-filled with ones. A partial vl, a nonzero vstart, and a mask with gaps should leave those ones visible. A design that cleared or wrote tail, prefix or inactive bits would show up there.
- A destination of v0 under masking. A design that re-read the mask after updating it would skip elements.
- Multi-register groups at every width. A design with a wrong register offset or byte slot would return data from the wrong register.
- Misaligned groups, and a `start` pulse while busy. A design that did not check would write the register file, or would produce a second completion.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    localparam int XW      = 64;
    localparam int NUM_VR  = 32;
    localparam int VR_W    = 5;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_LTU = 3'd2,
        CMP_LT  = 3'd3,
        CMP_LEU = 3'd4,
        CMP_LE  = 3'd5,
        CMP_GTU = 3'd6,
        CMP_GT  = 3'd7
    } cmp_op_e;

    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } ew_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOAD_MASK,
        ST_LOAD_DEST,
        ST_SCAN,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_WRITE,
        ST_DONE
    } state_e;

    typedef struct packed {
        cmp_op_e         op;
        ew_e             ew;
        logic [1:0]      grp_lg;
        logic [VR_W-1:0] vd;
        logic [VR_W-1:0] vs2;
        logic [VR_W-1:0] vs1;
        logic            use_scalar;
        logic [XW-1:0]   scalar;
        logic            vm;
    } cmd_t;

endpackage

// File: rtl/vcmp_group_check.sv
module vcmp_group_check
    import vcmp_pkg::*;
#(
    parameter int NREGS = NUM_VR
) (
    input  logic [VR_W-1:0] base,
    input  logic [1:0]      grp_lg,
    output logic            ok
);
    localparam int SPAN_W = VR_W + 1;

    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] limit;
    logic              aligned;
    logic              fits;

    always_comb begin
        span    = SPAN_W'(1) << grp_lg;
        limit   = {1'b0, base} + span;
        aligned = (base & VR_W'(span - SPAN_W'(1))) == '0;
        fits    = limit <= SPAN_W'(NREGS);
        ok      = aligned && fits;
    end
endmodule

// File: rtl/vcmp_elem_fetch.sv
module vcmp_elem_fetch
    import vcmp_pkg::*;
#(
    parameter int VLEN = 64
) (
    input  logic [VR_W-1:0]           base,
    input  logic [$clog2(VLEN):0]     idx,
    input  logic [1:0]                ew,
    input  logic [VLEN-1:0]           reg_data,
    output logic [VR_W-1:0]           reg_idx,
    output logic [XW-1:0]             elem
);
    localparam int VLENB = VLEN / 8;
    localparam int IDX_W = $clog2(VLEN) + 1;

    logic [IDX_W-1:0] offs [4];
    logic [XW-1:0]    vals [4];

    for (genvar s = 0; s < 4; s++) begin : g_ew
        localparam int EB  = 1 << s;
        localparam int EPR = VLENB / EB;
        localparam int SH  = $clog2(EPR);
        if (SH == 0) begin : g_one
            assign offs[s] = idx;
            assign vals[s] = XW'(reg_data[EB*8-1:0]);
        end else begin : g_many
            logic [SH-1:0] slot;
            assign slot    = idx[SH-1:0];
            assign offs[s] = idx >> SH;
            assign vals[s] = XW'(reg_data[int'(slot)*EB*8 +: EB*8]);
        end
    end

    always_comb begin
        reg_idx = base + VR_W'(offs[ew]);
        elem    = vals[ew];
    end
endmodule

// File: rtl/vcmp_compare.sv
module vcmp_compare
    import vcmp_pkg::*;
(
    input  logic [2:0]    op,
    input  logic [1:0]    ew,
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    output logic          hit
);
    logic [XW-1:0]        ua, ub;
    logic signed [XW-1:0] sa, sb;
    logic                 eq, ltu, lts;

    always_comb begin
        unique case (ew_e'(ew))
            EW8: begin
                ua = {56'd0, a[7:0]};
                ub = {56'd0, b[7:0]};
                sa = {{56{a[7]}}, a[7:0]};
                sb = {{56{b[7]}}, b[7:0]};
            end
            EW16: begin
                ua = {48'd0, a[15:0]};
                ub = {48'd0, b[15:0]};
                sa = {{48{a[15]}}, a[15:0]};
                sb = {{48{b[15]}}, b[15:0]};
            end
            EW32: begin
                ua = {32'd0, a[31:0]};
                ub = {32'd0, b[31:0]};
                sa = {{32{a[31]}}, a[31:0]};
                sb = {{32{b[31]}}, b[31:0]};
            end
            default: begin
                ua = a;
                ub = b;
                sa = a;
                sb = b;
            end
        endcase
        eq  = ua == ub;
        ltu = ua < ub;
        lts = sa < sb;
        unique case (cmp_op_e'(op))
            CMP_EQ:  hit = eq;
            CMP_NE:  hit = !eq;
            CMP_LTU: hit = ltu;
            CMP_LT:  hit = lts;
            CMP_LEU: hit = ltu || eq;
            CMP_LE:  hit = lts || eq;
            CMP_GTU: hit = !(ltu || eq);
            default: hit = !(lts || eq);
        endcase
    end
endmodule

// File: rtl/vcmp_mask_writer.sv
module vcmp_mask_writer
    import vcmp_pkg::*;
#(
    parameter int VLEN = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2:0]              op,
    input  logic [1:0]              ew,
    input  logic [1:0]              grp_lg,
    input  logic [4:0]              vd,
    input  logic [4:0]              vs2,
    input  logic [4:0]              vs1,
    input  logic                    use_scalar,
    input  logic [63:0]             scalar,
    input  logic                    vm,
    input  logic [$clog2(VLEN):0]   vl,
    input  logic [$clog2(VLEN):0]   vstart,
    output logic                    busy,
    output logic                    done,
    output logic                    illegal,
    output logic                    vstart_clr,
    output logic                    vs_dirty,
    output logic [4:0]              rf_rd_idx,
    input  logic [VLEN-1:0]         rf_rd_data,
    output logic                    rf_wr_en,
    output logic [4:0]              rf_wr_idx,
    output logic [VLEN-1:0]         rf_wr_data
);
    localparam int LGV   = $clog2(VLEN);
    localparam int IDX_W = LGV + 1;

    state_e           state_q, state_d;
    cmd_t             cmd_q;
    logic [IDX_W-1:0] vl_q, vstart_q, idx_q;
    logic [VLEN-1:0]  mask_q, dst_q;
    logic [XW-1:0]    a_q;
    logic             bad_q;

    logic             vs2_ok, vs1_ok, legal;
    logic [VR_W-1:0]  fetch_base, fetch_idx;
    logic [XW-1:0]    fetch_elem, cmp_a, cmp_b;
    logic             cmp_hit;
    logic             in_range, active;

    vcmp_group_check #(.NREGS(NUM_VR)) u_vs2_chk (
        .base(cmd_q.vs2), .grp_lg(cmd_q.grp_lg), .ok(vs2_ok)
    );
    vcmp_group_check #(.NREGS(NUM_VR)) u_vs1_chk (
        .base(cmd_q.vs1), .grp_lg(cmd_q.grp_lg), .ok(vs1_ok)
    );

    assign legal      = vs2_ok && (cmd_q.use_scalar || vs1_ok);
    assign fetch_base = (state_q == ST_FETCH_B) ? cmd_q.vs1 : cmd_q.vs2;

    vcmp_elem_fetch #(.VLEN(VLEN)) u_fetch (
        .base(fetch_base), .idx(idx_q), .ew(cmd_q.ew),
        .reg_data(rf_rd_data), .reg_idx(fetch_idx), .elem(fetch_elem)
    );

    assign cmp_a = cmd_q.use_scalar ? fetch_elem : a_q;
    assign cmp_b = cmd_q.use_scalar ? cmd_q.scalar : fetch_elem;

    vcmp_compare u_cmp (
        .op(cmd_q.op), .ew(cmd_q.ew), .a(cmp_a), .b(cmp_b), .hit(cmp_hit)
    );

    assign in_range = idx_q < vl_q;
    assign active   = mask_q[idx_q[LGV-1:0]];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!legal)         state_d = ST_DONE;
                else if (!cmd_q.vm) state_d = ST_LOAD_MASK;
                else                state_d = ST_LOAD_DEST;
            end
            ST_LOAD_MASK: state_d = ST_LOAD_DEST;
            ST_LOAD_DEST: state_d = ST_SCAN;
            ST_SCAN: begin
                if (!in_range)   state_d = ST_WRITE;
                else if (active) state_d = ST_FETCH_A;
            end
            ST_FETCH_A:   state_d = cmd_q.use_scalar ? ST_SCAN : ST_FETCH_B;
            ST_FETCH_B:   state_d = ST_SCAN;
            ST_WRITE:     state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            vl_q     <= '0;
            vstart_q <= '0;
            idx_q    <= '0;
            mask_q   <= '0;
            dst_q    <= '0;
            a_q      <= '0;
            bad_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cmd_q    <= '{op: cmp_op_e'(op), ew: ew_e'(ew), grp_lg: grp_lg,
                                  vd: vd, vs2: vs2, vs1: vs1, use_scalar: use_scalar,
                                  scalar: scalar, vm: vm};
                    vl_q     <= vl;
                    vstart_q <= vstart;
                    mask_q   <= '1;
                    bad_q    <= 1'b0;
                end
                ST_CHECK:     bad_q  <= !legal;
                ST_LOAD_MASK: mask_q <= rf_rd_data;
                ST_LOAD_DEST: begin
                    dst_q <= rf_rd_data;
                    idx_q <= vstart_q;
                end
                ST_SCAN: if (in_range && !active) idx_q <= idx_q + 1'b1;
                ST_FETCH_A: begin
                    a_q <= fetch_elem;
                    if (cmd_q.use_scalar) begin
                        dst_q[idx_q[LGV-1:0]] <= cmp_hit;
                        idx_q                 <= idx_q + 1'b1;
                    end
                end
                ST_FETCH_B: begin
                    dst_q[idx_q[LGV-1:0]] <= cmp_hit;
                    idx_q                 <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = state_q != ST_IDLE;
        done       = 1'b0;
        illegal    = 1'b0;
        vstart_clr = 1'b0;
        vs_dirty   = 1'b0;
        rf_rd_idx  = '0;
        rf_wr_en   = 1'b0;
        rf_wr_idx  = cmd_q.vd;
        rf_wr_data = dst_q;
        unique case (state_q)
            ST_LOAD_MASK: rf_rd_idx = '0;
            ST_LOAD_DEST: rf_rd_idx = cmd_q.vd;
            ST_FETCH_A,
            ST_FETCH_B:   rf_rd_idx = fetch_idx;
            ST_WRITE:     rf_wr_en  = 1'b1;
            ST_DONE: begin
                done       = 1'b1;
                illegal    = bad_q;
                vstart_clr = !bad_q;
                vs_dirty   = !bad_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vcmp_mask_writer_chk.sv
module vcmp_mask_writer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [4:0] vd,
    input logic       busy,
    input logic       done,
    input logic       illegal,
    input logic       vstart_clr,
    input logic       vs_dirty,
    input logic       rf_wr_en,
    input logic [4:0] rf_wr_idx
);
    logic [4:0] vd_seen;
    logic [1:0] wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_seen <= '0;
            wr_cnt  <= '0;
        end else if (start && !busy) begin
            vd_seen <= vd;
            wr_cnt  <= '0;
        end else if (rf_wr_en && wr_cnt != 2'd3) begin
            wr_cnt <= wr_cnt + 2'd1;
        end
    end

    assert_write_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> rf_wr_idx == vd_seen);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_flags_need_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vstart_clr || vs_dirty || illegal) |-> done);
    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |-> wr_cnt == 2'd1);
    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!vs_dirty && !vstart_clr && wr_cnt == 2'd0));
    assert_accept_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_hold_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_return_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind vcmp_mask_writer vcmp_mask_writer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vd(vd), .busy(busy),
    .done(done), .illegal(illegal), .vstart_clr(vstart_clr),
    .vs_dirty(vs_dirty), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx)
);

// File: tb/vcmp_mask_writer_test.sv
`timescale 1ns/1ps
module vcmp_mask_writer_test;
    localparam int VLEN  = 64;
    localparam int IDX_W = $clog2(VLEN) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = '0;
    logic [1:0] ew = '0, grp_lg = '0;
    logic [4:0] vd = '0, vs2 = '0, vs1 = '0;
    logic use_scalar = 1'b0, vm = 1'b1;
    logic [63:0] scalar = '0;
    logic [IDX_W-1:0] vl = '0, vstart = '0;
    logic busy, done, illegal, vstart_clr, vs_dirty, rf_wr_en;
    logic [4:0] rf_rd_idx, rf_wr_idx;
    logic [VLEN-1:0] rf_rd_data, rf_wr_data;

    logic [VLEN-1:0] rf [32];
    logic pl_en = 1'b0;
    logic [4:0] pl_idx = '0;
    logic [VLEN-1:0] pl_data = '0;
    int wr_total = 0;
    int last_total = 0;
    int checks = 0, errors = 0;
    bit finished = 0;

    typedef struct {
        logic [4:0]      vd;
        logic [VLEN-1:0] dst;
        bit              bad;
        string           tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    assign rf_rd_data = rf[rf_rd_idx];
    always @(posedge clk) begin
        if (rf_wr_en) begin
            rf[rf_wr_idx] <= rf_wr_data;
            wr_total <= wr_total + 1;
        end else if (pl_en) rf[pl_idx] <= pl_data;
    end

    vcmp_mask_writer #(.VLEN(VLEN)) uut (.*);

    task automatic check(bit ok, string tag, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] get_elem(int base, int i, int eb);
        int epr = VLEN / 8 / eb;
        int r = base + i / epr;
        int byo = (i % epr) * eb;
        logic [63:0] v = '0;
        for (int k = 0; k < eb; k++) v[k*8 +: 8] = rf[r][(byo + k)*8 +: 8];
        return v;
    endfunction

    function automatic bit ref_cmp(int opc, int eb, logic [63:0] a, logic [63:0] b);
        int sh = 64 - 8 * eb;
        logic [63:0] ua = (a << sh) >> sh;
        logic [63:0] ub = (b << sh) >> sh;
        logic signed [63:0] sa = $signed(a << sh) >>> sh;
        logic signed [63:0] sb = $signed(b << sh) >>> sh;
        case (opc)
            0: return ua == ub;
            1: return ua != ub;
            2: return ua < ub;
            3: return sa < sb;
            4: return ua <= ub;
            5: return sa <= sb;
            6: return ua > ub;
            default: return sa > sb;
        endcase
    endfunction

    task automatic setreg(int idx, logic [VLEN-1:0] data);
        @(negedge clk);
        pl_en = 1'b1; pl_idx = 5'(idx); pl_data = data;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic launch(int opc, int ewc, int glg, int d, int s2, int s1, bit usc,
                          logic [63:0] sc, bit m, int len, int st, string tag);
        exp_t e;
        int g = 1 << glg;
        int eb = 1 << ewc;
        e.vd = 5'(d);
        e.tag = tag;
        e.bad = (s2 % g != 0) || (!usc && (s1 % g != 0));
        e.dst = rf[d];
        if (!e.bad)
            for (int i = st; i < len; i++)
                if (m || rf[0][i])
                    e.dst[i] = ref_cmp(opc, eb, get_elem(s2, i, eb),
                                       usc ? sc : get_elem(s1, i, eb));
        sb_q.push_back(e);
        @(negedge clk);
        op = 3'(opc); ew = 2'(ewc); grp_lg = 2'(glg); vd = 5'(d); vs2 = 5'(s2);
        vs1 = 5'(s1); use_scalar = usc; scalar = sc; vm = m;
        vl = IDX_W'(len); vstart = IDX_W'(st); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic await_done();
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic run(int opc, int ewc, int glg, int d, int s2, int s1, bit usc,
                       logic [63:0] sc, bit m, int len, int st, string tag);
        launch(opc, ewc, glg, d, s2, s1, usc, sc, m, len, st, tag);
        await_done();
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11 unexpected done", VLEN'(1), VLEN'(0));
            end else begin
                exp_t e;
                int w;
                e = sb_q.pop_front();
                w = wr_total - last_total;
                last_total = wr_total;
                check(illegal == e.bad, {e.tag, " R9 illegal flag"}, VLEN'(illegal), VLEN'(e.bad));
                check(vstart_clr == !e.bad && vs_dirty == !e.bad, {e.tag, " R10 flags"},
                      VLEN'({vstart_clr, vs_dirty}), VLEN'({!e.bad, !e.bad}));
                check(w == (e.bad ? 0 : 1), {e.tag, " R10 write count"}, VLEN'(w), VLEN'(!e.bad));
                check(rf[e.vd] === e.dst, {e.tag, " dest"}, rf[e.vd], e.dst);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 32; r++) rf[r] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        check(!busy && !done && !rf_wr_en, "R11 reset idle",
              VLEN'({busy, done, rf_wr_en}), VLEN'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: byte eq, one register
        setreg(4, 64'h1122334455667788);
        setreg(5, 64'h1122FF4455AA7788);
        run(0, 0, 0, 3, 4, 5, 0, 0, 1, 8, 0, "R1 R2 eq ew8");
        run(1, 0, 0, 3, 4, 5, 0, 0, 1, 8, 0, "R1 R2 ne ew8");

        // R2 R3: sign bit at ew16
        setreg(6, 64'h8000_0001_7FFF_FFFF);
        setreg(7, 64'h0001_8000_8000_0001);
        for (int o = 2; o < 8; o++) run(o, 1, 0, 9, 6, 7, 0, 0, 1, 4, 0, "R2 R3 ew16 relation");

        // R4: ew32 group of 2, all relations
        setreg(8,  64'h0000_0005_FFFF_FFF0);
        setreg(9,  64'h8000_0000_1234_5678);
        setreg(10, 64'h0000_0005_0000_0010);
        setreg(11, 64'h7FFF_FFFF_1234_5678);
        for (int o = 0; o < 8; o++) run(o, 2, 1, 1, 8, 10, 0, 0, 1, 4, 0, "R4 ew32 group2");

        // R4: ew64 group of 8
        for (int o = 2; o < 8; o += 2) run(o + 1, 3, 3, 2, 16, 24, 0, 0, 1, 8, 0, "R4 ew64 group8");
        run(2, 3, 3, 2, 16, 24, 0, 0, 1, 8, 0, "R4 ew64 ltu group8");

        // R5: tail kept
        setreg(12, '1);
        run(0, 0, 2, 12, 4, 4, 0, 0, 1, 20, 0, "R5 tail ew8 group4");
        setreg(12, '1);
        run(1, 0, 0, 12, 4, 4, 0, 0, 1, 5, 0, "R5 tail short vl");

        // R6: prefix kept, empty range
        setreg(13, '1);
        run(1, 0, 0, 13, 4, 4, 0, 0, 1, 8, 3, "R6 vstart prefix");
        run(0, 0, 0, 13, 4, 5, 0, 0, 1, 4, 6, "R6 vstart beyond vl");

        // R7: masking by v0, destination v0
        setreg(0, 64'h0000_0000_0000_00A5);
        setreg(14, '1);
        run(1, 0, 0, 14, 4, 4, 0, 0, 0, 8, 0, "R7 masked");
        run(1, 0, 0, 0, 4, 4, 0, 0, 0, 8, 0, "R7 masked into v0");

        // R8: scalar operand, vs1 ignored even if misaligned
        run(3, 2, 1, 15, 8, 3, 1, 64'hFFFF_FFFF_FFFF_FFFE, 1, 4, 0, "R8 scalar lt");
        run(2, 2, 1, 15, 8, 3, 1, 64'hFFFF_FFFF_FFFF_FFFE, 1, 4, 0, "R8 scalar ltu");
        run(0, 2, 1, 15, 8, 3, 1, 64'h0000_1234_0000_0005, 1, 4, 0, "R8 scalar high bits");

        // R9: illegal grouping
        run(0, 0, 1, 17, 3, 4, 0, 0, 1, 8, 0, "R9 vs2 misaligned");
        run(0, 0, 2, 17, 8, 6, 0, 0, 1, 8, 0, "R9 vs1 misaligned");

        // R11: start while busy ignored
        launch(0, 0, 0, 18, 4, 5, 0, 0, 1, 8, 0, "R11 first command");
        repeat (2) @(negedge clk);
        vd = 5'd19; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        await_done();
        repeat (20) @(negedge clk);
        check(sb_q.size() == 0 && wr_total == last_total, "R11 no second command",
              VLEN'(wr_total - last_total), VLEN'(0));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule